// File: doc/BRIEF.md
# Multimode Addressable Output Latch

The block stores eight bits. A 3-bit select picks one of them. An active-low clear and an active-low enable together choose one of four modes:

- write the data bit into the selected position;
- hold every bit;
- route the data bit to the selected position and clear all the others;
- clear every bit.

Each output is an active-low drive line. A stored 1 pulls its line low (on). A stored 0 leaves its line high (off).

Storage is clocked. The mode, select and data inputs are sampled on every rising edge of the system clock. A second output gives the stored bits in true polarity, so surrounding logic and test can observe the state directly.

Top module: `addr_latch`

## Requirements
- R1: Select value n (0 to 7) addresses storage bit n, which appears on store_o[n] and drv_no[n].
- R2: With clr_ni=1 and en_ni=0, a rising clock edge writes data_i into the addressed bit and leaves the other seven bits unchanged.
- R3: With clr_ni=1 and en_ni=1, a rising clock edge leaves all eight bits unchanged, whatever data_i and sel_i are.
- R4: With clr_ni=0 and en_ni=0, a rising clock edge loads data_i into the addressed bit and forces every other bit to 0.
- R5: With clr_ni=0 and en_ni=1, a rising clock edge forces all eight bits to 0.
- R6: drv_no is at all times the bitwise inverse of store_o: a stored 1 drives its line low, and a stored 0 leaves it high.
- R7: While rst_ni is low, all bits are 0 and all drv_no lines are 1, with no clock edge needed.
- R8: A change caused by the sampled mode appears on the outputs right after the rising edge that samples it. Before that edge the outputs do not change.
- R9: When the select moves to another bit in write mode, the previously addressed bit keeps the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Data bit |
| sel_i | input | 3 | Bit address |
| en_ni | input | 1 | Active-low enable |
| clr_ni | input | 1 | Active-low clear |
| drv_no | output | 8 | Active-low drive lines |
| store_o | output | 8 | Stored bits, true polarity |

## Verification
The assertions assume that clr_ni, en_ni, sel_i and data_i have known, settled values at every rising edge. Under that assumption, a property such as "the bits that are not addressed stay put in write mode" can be stated over whole cycles. The bench changes every input only on the falling clock edge, so the values are settled half a period before they are sampled. It also samples the outputs on the following falling edge, one register stage after the mode was applied.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_e;
endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  en_ni,
  input  logic  clr_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({clr_ni, en_ni})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch_sel_dec.sv
module addr_latch_sel_dec #(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input  logic [SEL_W-1:0]    sel_i,
  output logic [NUM_BITS-1:0] hit_o
);
  for (genvar g = 0; g < NUM_BITS; g++) begin : g_hit
    assign hit_o[g] = (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
  import addr_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  hit_i,
  input  logic  data_i,
  output logic  q_o
);
  logic q_d;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: q_d = hit_i ? data_i : q_o;
      MODE_HOLD:  q_d = q_o;
      MODE_DEMUX: q_d = hit_i & data_i;
      default:    q_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                en_ni,
  input  logic                clr_ni,
  output logic [NUM_BITS-1:0] drv_no,
  output logic [NUM_BITS-1:0] store_o
);
  mode_e               mode;
  logic [NUM_BITS-1:0] hit;

  addr_latch_mode_dec u_mode (
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .mode_o (mode)
  );

  addr_latch_sel_dec #(.NUM_BITS(NUM_BITS)) u_sel (
    .sel_i (sel_i),
    .hit_o (hit)
  );

  for (genvar g = 0; g < NUM_BITS; g++) begin : g_cell
    addr_latch_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .hit_i  (hit[g]),
      .data_i (data_i),
      .q_o    (store_o[g])
    );
  end

  // open-drain style: stored 1 pulls line low
  assign drv_no = ~store_o;
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int NUM_BITS = 8,
  localparam int SEL_W = $clog2(NUM_BITS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                data_i,
  input logic [SEL_W-1:0]    sel_i,
  input logic                en_ni,
  input logic                clr_ni,
  input logic [NUM_BITS-1:0] drv_no,
  input logic [NUM_BITS-1:0] store_o
);
  p_keep_others_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !en_ni) |=>
      ((store_o & ~(NUM_BITS'(1) << $past(sel_i))) ==
       ($past(store_o) & ~(NUM_BITS'(1) << $past(sel_i)))));

  p_write_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !en_ni) |=> (store_o[$past(sel_i)] == $past(data_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && en_ni) |=> $stable(store_o));

  p_demux_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !en_ni) |=>
      (store_o == (NUM_BITS'($past(data_i)) << $past(sel_i))));

  p_demux_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !en_ni) |=> $onehot0(store_o));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && en_ni) |=> (store_o == '0));

  p_polarity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_no == ~store_o));
endmodule

bind addr_latch addr_latch_chk #(.NUM_BITS(NUM_BITS)) u_chk (.*);

// File: tb/addr_latch_tb_top.sv
module addr_latch_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       en_ni = 1'b1;
  logic       clr_ni = 1'b1;
  logic [7:0] drv_no, store_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  addr_latch dut_i (.*);

  // {clr_ni, en_ni, sel, data, expected store}
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 1'b1, 8'h01},
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h81},
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h89},
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h89},
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h88},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'hA8},
    {1'b1, 1'b1, 3'd2, 1'b0, 8'hA8},
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
    {1'b0, 1'b0, 3'd6, 1'b0, 8'h00},
    {1'b0, 1'b0, 3'd6, 1'b1, 8'h40},
    {1'b1, 1'b0, 3'd1, 1'b1, 8'h42},
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h00},
    {1'b1, 1'b0, 3'd4, 1'b1, 8'h10},
    {1'b1, 1'b0, 3'd2, 1'b1, 8'h14},
    {1'b0, 1'b0, 3'd4, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h80}
  };

  task automatic check(input string tag, input logic [7:0] exp);
    n_chk++;
    if (store_o !== exp || drv_no !== ~exp) begin
      n_bad++;
      $display("FAIL %s: store=%h drv=%h expected store=%h drv=%h",
               tag, store_o, drv_no, exp, ~exp);
    end
  endtask

  task automatic drive(input logic c, input logic e, input logic [2:0] s, input logic d);
    clr_ni = c; en_ni = e; sel_i = s; data_i = d;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    // R7: reset state
    #1 check("R7 reset", 8'h00);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      unique case (VEC[i][13:12])
        2'b10:   tag = "R1 R2 R6 write";
        2'b11:   tag = "R3 R6 hold";
        2'b00:   tag = "R1 R4 R6 demux";
        default: tag = "R5 R6 clear";
      endcase
      @(negedge clk_i);
      check($sformatf("%s vec %0d", tag, i), VEC[i][7:0]);
    end
    // store = 80 here; hold while inputs toggle (R3)
    drive(1'b1, 1'b1, 3'd0, 1'b1);
    @(negedge clk_i);
    sel_i = 3'd3; data_i = 1'b0;
    @(negedge clk_i);
    check("R3 hold with toggling inputs", 8'h80);

    // R8: no change before the sampling edge
    drive(1'b1, 1'b0, 3'd3, 1'b1);
    @(posedge clk_i); #1;
    check("R8 after sampling edge", 8'h88);
    drive(1'b1, 1'b1, 3'd6, 1'b1);
    #2;
    check("R8 no change before edge", 8'h88);

    // R9: address moves in write mode
    @(negedge clk_i);
    drive(1'b1, 1'b0, 3'd4, 1'b0);
    @(negedge clk_i);
    check("R9 prior bit kept", 8'h88);

    // R4 demux with data 1 at bit 7
    drive(1'b0, 1'b0, 3'd7, 1'b1);
    @(negedge clk_i);
    check("R4 demux top bit", 8'h80);

    // R7: asynchronous reset mid-cycle
    drive(1'b1, 1'b0, 3'd0, 1'b1);
    @(negedge clk_i);
    check("R2 write bit0", 8'h81);
    #1 rst_ni = 1'b0;
    #1 check("R7 async reset", 8'h00);
    @(negedge clk_i);
    check("R7 held in reset", 8'h00);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule